// File: doc/BRIEF.md
# Interrupt and Cyclic Wake Controller

This block gathers the interrupt sources of a CAN system basis chip into one status register and drives a single active-low interrupt request. The request is modelled as an output enable: when it is high, an external open-drain pad pulls the line low. Software reads the status register over a small register bus. It acknowledges an interrupt by writing 1 to that bit. A CAN wake-up also sets a pending-wake flag. That flag is kept apart from its status bit, so that acknowledging the interrupt in Standby does not discard the wake-up.

A cyclic interrupt alerts a sleeping microcontroller each time the watchdog, running in timeout mode, overflows. The cyclic source is armed on the cycle the watchdog switches into timeout mode, but only while the chip is in Normal or Standby mode and the watchdog-disable pin is low. After that, every overflow raises the cyclic status bit. The microcontroller polls the register, sees that it was woken cyclically, does a few checks and goes back to sleep.

Status bit layout: bit 0 is CAN wake-up, bit 1 is cyclic interrupt, and bits 2 and up are the general event inputs in index order. Operating mode code: 0 Normal, 1 Standby, 2 Sleep, 3 Overtemp. Watchdog mode code: 0 off, 1 window, 2 timeout.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the status register reads 0, `wakePending` is 0 and `irqOe` is 0. After that, `irqOe` is 1 exactly when at least one status bit is set.
- R2: A write to the status address clears each status bit whose data bit is 1. Bits written as 0 are unchanged, and writes to any other address leave the register unchanged.
- R3: When an event and a write-1 to the same bit fall in the same cycle, the bit ends up set.
- R4: A read at the status address returns the status bits, with bit 0 the CAN wake-up and bit 1 the cyclic interrupt. A read at any other address returns 0. Reads never change the register.
- R5: While the operating mode is Standby (code 1), writing 1 to status bit 0 clears only that status bit and `wakePending` stays 1. In any other mode the same write also clears `wakePending`.
- R6: `wakePending` is set by `canWakeEvt`. It is cleared when the operating mode changes into Normal (code 0) from another mode with `stbyCtl` at 0. It is kept when `stbyCtl` is 1 at that change, and kept while the mode simply stays Normal.
- R7: The cyclic source is armed in the cycle the watchdog mode changes into timeout (code 2), provided the operating mode is Normal or Standby and `wdDisPin` is 0. Entry in Sleep, or with `wdDisPin` high, leaves it unarmed.
- R8: While armed and in timeout mode, each `wdOverflow` pulse sets status bit 1. An overflow while unarmed sets nothing.
- R9: The cyclic source is disarmed when the watchdog leaves timeout mode or `wdDisPin` goes high. It re-arms only on a fresh entry into timeout mode.
- R10: A pulse on `genEvt[i]` sets status bit 2+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opMode | input | 2 | Operating mode: 0 Normal, 1 Standby, 2 Sleep, 3 Overtemp |
| wdMode | input | 2 | Watchdog mode: 0 off, 1 window, 2 timeout |
| wdOverflow | input | 1 | One-cycle watchdog overflow strobe |
| wdDisPin | input | 1 | Watchdog-disable pin level, high disables |
| stbyCtl | input | 1 | Standby-control bit |
| canWakeEvt | input | 1 | One-cycle CAN wake-up strobe |
| genEvt | input | NUM_GEN | One-cycle general event strobes |
| busSel | input | 1 | Register bus select |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | NUM_GEN+2 | Write data, 1 clears the bit |
| busRdata | output | NUM_GEN+2 | Read data, combinational |
| irqOe | output | 1 | Pull-down enable for the open-drain interrupt pad |
| wakePending | output | 1 | Pending CAN wake-up flag |

## Verification
The assertions check four things on every cycle:
- `irqOe` agrees with the OR of the status bits.
- A wake event always leaves bit 0 set, and a clear with no competing event drops it.
- A Standby acknowledge never drops the pending wake.
- The cyclic bit rises only after an overflow.

Only the bench's scenarios can show the behaviour that depends on history:
- arming on entry into timeout mode, and refusal to arm in Sleep or with the disable pin high;
- disarming without a fresh entry;
- the pending wake surviving or not across mode changes with each value of `stbyCtl`.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;

  typedef enum logic [1:0] {
    OP_NORMAL   = 2'd0,
    OP_STANDBY  = 2'd1,
    OP_SLEEP    = 2'd2,
    OP_OVERTEMP = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    WD_OFF     = 2'd0,
    WD_WINDOW  = 2'd1,
    WD_TIMEOUT = 2'd2,
    WD_RSVD    = 2'd3
  } wd_mode_e;

  localparam int WAKE_BIT = 0;
  localparam int CYC_BIT  = 1;
  localparam int GEN_BASE = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrHit;      // bus write to the status address
    logic ciSet;      // cyclic interrupt fires this cycle
    logic pendDrop;   // entry into Normal with standby control off
    logic inStandby;  // current mode is Standby
  } ctl_strb_t;

endpackage

// File: rtl/irq_wake_ctl.sv
module irq_wake_ctl
  import irq_wake_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opMode,
  input  logic [1:0]        wdMode,
  input  logic              wdOverflow,
  input  logic              wdDisPin,
  input  logic              stbyCtl,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctl_strb_t         strb
);

  op_mode_e curOp, prevOp;
  wd_mode_e curWd, prevWd;
  logic     armQ, armNxt;
  logic     modeOk, wdEnter, inTimeout;

  always_comb begin
    curOp     = op_mode_e'(opMode);
    curWd     = wd_mode_e'(wdMode);
    modeOk    = (curOp == OP_NORMAL) || (curOp == OP_STANDBY);
    inTimeout = (curWd == WD_TIMEOUT);
    wdEnter   = inTimeout && (prevWd != WD_TIMEOUT);
    if (wdDisPin || !inTimeout) begin
      armNxt = 1'b0;
    end else if (wdEnter && modeOk) begin
      armNxt = 1'b1;
    end else begin
      armNxt = armQ;
    end
  end

  always_comb begin
    strb.wrHit     = busSel && busWr && (busAddr == STATUS_ADDR);
    strb.ciSet     = armQ && inTimeout && wdOverflow && !wdDisPin;
    strb.pendDrop  = (curOp == OP_NORMAL) && (prevOp != OP_NORMAL) && !stbyCtl;
    strb.inStandby = (curOp == OP_STANDBY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOp <= OP_NORMAL;
      prevWd <= WD_OFF;
      armQ   <= 1'b0;
    end else begin
      prevOp <= curOp;
      prevWd <= curWd;
      armQ   <= armNxt;
    end
  end

endmodule

// File: rtl/irq_wake_dp.sv
module irq_wake_dp
  import irq_wake_pkg::*;
#(
  parameter int NUM_GEN = 6,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 2,
  localparam int STAT_W = NUM_GEN + GEN_BASE
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strb_t         strb,
  input  logic              canWakeEvt,
  input  logic [NUM_GEN-1:0] genEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [STAT_W-1:0] busWdata,
  output logic [STAT_W-1:0] busRdata,
  output logic [STAT_W-1:0] statusQ,
  output logic              wakePending,
  output logic              irqOe
);

  logic [STAT_W-1:0] setVec, clrVec, statusNxt;
  logic              pendNxt;

  assign setVec[WAKE_BIT] = canWakeEvt;
  assign setVec[CYC_BIT]  = strb.ciSet;

  for (genvar gi = 0; gi < NUM_GEN; gi++) begin : g_gen
    assign setVec[GEN_BASE + gi] = genEvt[gi];
  end

  always_comb begin
    clrVec    = strb.wrHit ? busWdata : '0;
    statusNxt = setVec | (statusQ & ~clrVec);
    if (canWakeEvt) begin
      pendNxt = 1'b1;
    end else if (strb.pendDrop) begin
      pendNxt = 1'b0;
    end else if (clrVec[WAKE_BIT] && !strb.inStandby) begin
      pendNxt = 1'b0;
    end else begin
      pendNxt = wakePending;
    end
  end

  assign busRdata = (busAddr == STATUS_ADDR) ? statusQ : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ     <= '0;
      wakePending <= 1'b0;
      irqOe       <= 1'b0;
    end else begin
      statusQ     <= statusNxt;
      wakePending <= pendNxt;
      irqOe       <= |statusNxt;
    end
  end

endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int NUM_GEN = 6,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 2,
  localparam int STAT_W = NUM_GEN + GEN_BASE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         opMode,
  input  logic [1:0]         wdMode,
  input  logic               wdOverflow,
  input  logic               wdDisPin,
  input  logic               stbyCtl,
  input  logic               canWakeEvt,
  input  logic [NUM_GEN-1:0] genEvt,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [STAT_W-1:0]  busWdata,
  output logic [STAT_W-1:0]  busRdata,
  output logic               irqOe,
  output logic               wakePending
);

  ctl_strb_t         strb;
  logic [STAT_W-1:0] statusQ;

  irq_wake_ctl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .opMode(opMode), .wdMode(wdMode),
    .wdOverflow(wdOverflow), .wdDisPin(wdDisPin), .stbyCtl(stbyCtl),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .strb(strb)
  );

  irq_wake_dp #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .canWakeEvt(canWakeEvt),
    .genEvt(genEvt), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .statusQ(statusQ), .wakePending(wakePending),
    .irqOe(irqOe)
  );

endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk #(
  parameter int ADDR_W = 4,
  parameter int STAT_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        opMode,
  input logic              wdOverflow,
  input logic              canWakeEvt,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [STAT_W-1:0] busWdata,
  input logic [STAT_W-1:0] statusQ,
  input logic              irqOe,
  input logic              wakePending
);

  logic wakeClrHit;
  assign wakeClrHit = busSel && busWr && (busAddr == STATUS_ADDR) && busWdata[0];

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    irqOe == (|statusQ)); // R1

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wakeClrHit && !canWakeEvt) |=> !statusQ[0]); // R2

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    canWakeEvt |=> statusQ[0]); // R3

  AST_STBY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (wakeClrHit && opMode == 2'd1 && wakePending) |=> wakePending); // R5

  AST_PEND_WITH_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakePending) |-> statusQ[0]); // R6

  AST_CI_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[1]) |-> $past(wdOverflow)); // R8

endmodule

bind irq_wake_ctrl irq_wake_chk #(
  .ADDR_W(ADDR_W), .STAT_W(STAT_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (.*);

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;

  localparam int NUM_GEN = 6;
  localparam int ADDR_W  = 4;
  localparam int STAT_W  = NUM_GEN + 2;
  localparam logic [ADDR_W-1:0] SADDR = 4'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] opMode = 2'd0;
  logic [1:0] wdMode = 2'd0;
  logic wdOverflow = 1'b0, wdDisPin = 1'b0, stbyCtl = 1'b0, canWakeEvt = 1'b0;
  logic [NUM_GEN-1:0] genEvt = '0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [STAT_W-1:0] busWdata = '0;
  logic [STAT_W-1:0] busRdata;
  logic irqOe, wakePending;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_wake_ctrl #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W), .STATUS_ADDR(SADDR)) u_dut (
    .clk(clk), .rstN(rstN), .opMode(opMode), .wdMode(wdMode),
    .wdOverflow(wdOverflow), .wdDisPin(wdDisPin), .stbyCtl(stbyCtl),
    .canWakeEvt(canWakeEvt), .genEvt(genEvt), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOe(irqOe), .wakePending(wakePending)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [STAT_W-1:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    cyc();
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [STAT_W-1:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic t_reset();
    logic [STAT_W-1:0] r;
    busRead(SADDR, r);
    check("R1 reset status", r, 0);
    check("R1 reset irqOe", irqOe, 0);
    check("R1 reset pending", wakePending, 0);
  endtask

  task automatic t_gen_clear();
    logic [STAT_W-1:0] r;
    genEvt = 6'b000101; cyc(); genEvt = '0;
    busRead(SADDR, r);
    check("R10 gen bits", r, 8'h14);
    check("R1 irq on", irqOe, 1);
    busWrite(SADDR, 8'h00);
    busRead(SADDR, r);
    check("R2 zero write", r, 8'h14);
    busWrite(SADDR, 8'h04);
    busRead(SADDR, r);
    check("R2 partial clear", r, 8'h10);
    check("R1 irq still on", irqOe, 1);
    busWrite(4'd5, 8'hFF);
    busRead(SADDR, r);
    check("R2 other addr", r, 8'h10);
    busWrite(SADDR, 8'h10);
    busRead(SADDR, r);
    check("R2 full clear", r, 8'h00);
    check("R1 irq off", irqOe, 0);
  endtask

  task automatic t_evt_wins();
    logic [STAT_W-1:0] r;
    genEvt = 6'b000010; cyc(); genEvt = '0;
    genEvt = 6'b000010;
    busWrite(SADDR, 8'h08);
    genEvt = '0;
    busRead(SADDR, r);
    check("R3 event beats clear", r, 8'h08);
    busWrite(SADDR, 8'h08);
    busRead(SADDR, r);
    check("R3 later clear", r, 8'h00);
  endtask

  task automatic t_read();
    logic [STAT_W-1:0] r;
    genEvt = 6'b100000; cyc(); genEvt = '0;
    busRead(SADDR, r);
    check("R4 first read", r, 8'h80);
    cyc();
    busRead(SADDR, r);
    check("R4 repeat read", r, 8'h80);
    busRead(4'd7, r);
    check("R4 other addr read", r, 8'h00);
    busWrite(SADDR, 8'h80);
  endtask

  task automatic t_standby();
    logic [STAT_W-1:0] r;
    opMode = 2'd1; cyc();
    canWakeEvt = 1'b1; cyc(); canWakeEvt = 1'b0;
    busRead(SADDR, r);
    check("R4 wake bit", r, 8'h01);
    check("R6 pending set", wakePending, 1);
    busWrite(SADDR, 8'h01);
    busRead(SADDR, r);
    check("R5 standby status cleared", r, 8'h00);
    check("R5 standby pending kept", wakePending, 1);
    check("R1 irq released", irqOe, 0);
    opMode = 2'd2; cyc();
    canWakeEvt = 1'b1; cyc(); canWakeEvt = 1'b0;
    busWrite(SADDR, 8'h01);
    check("R5 sleep clear drops pending", wakePending, 0);
  endtask

  task automatic t_normal_entry();
    canWakeEvt = 1'b1; cyc(); canWakeEvt = 1'b0;
    stbyCtl = 1'b1; opMode = 2'd0; cyc();
    check("R6 kept with stbyCtl", wakePending, 1);
    stbyCtl = 1'b0; cyc();
    check("R6 kept staying normal", wakePending, 1);
    opMode = 2'd1; cyc();
    opMode = 2'd0; cyc();
    check("R6 dropped on entry", wakePending, 0);
    busWrite(SADDR, 8'h01);
  endtask

  task automatic t_cyclic();
    logic [STAT_W-1:0] r;
    opMode = 2'd1; wdDisPin = 1'b0; wdMode = 2'd2; cyc();
    wdOverflow = 1'b1; cyc(); wdOverflow = 1'b0;
    busRead(SADDR, r);
    check("R8 first overflow", r, 8'h02);
    busWrite(SADDR, 8'h02);
    wdOverflow = 1'b1; cyc(); wdOverflow = 1'b0;
    busRead(SADDR, r);
    check("R8 second overflow", r, 8'h02);
    busWrite(SADDR, 8'h02);
    wdDisPin = 1'b1; cyc(); wdDisPin = 1'b0; cyc();
    wdOverflow = 1'b1; cyc(); wdOverflow = 1'b0;
    busRead(SADDR, r);
    check("R9 disarmed by pin", r, 8'h00);
    wdMode = 2'd0; cyc();
    opMode = 2'd2; wdMode = 2'd2; cyc();
    wdOverflow = 1'b1; cyc(); wdOverflow = 1'b0;
    busRead(SADDR, r);
    check("R7 no arm in sleep", r, 8'h00);
    wdMode = 2'd0; opMode = 2'd0; cyc();
    wdDisPin = 1'b1; wdMode = 2'd2; cyc();
    wdDisPin = 1'b0; cyc();
    wdOverflow = 1'b1; cyc(); wdOverflow = 1'b0;
    busRead(SADDR, r);
    check("R7 no arm with pin high", r, 8'h00);
    wdMode = 2'd0; cyc();
    wdMode = 2'd2; cyc();
    wdOverflow = 1'b1; cyc(); wdOverflow = 1'b0;
    busRead(SADDR, r);
    check("R7 armed in normal", r, 8'h02);
    busWrite(SADDR, 8'h02);
    wdMode = 2'd1; cyc();
    wdMode = 2'd2; wdOverflow = 1'b1; cyc(); wdOverflow = 1'b0;
    busRead(SADDR, r);
    check("R9 left timeout then overflow on entry", r, 8'h00);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rstN = 1'b1;
    cyc();
    t_gen_clear();
    t_evt_wins();
    t_read();
    t_standby();
    t_normal_entry();
    t_cyclic();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule